// File: doc/BRIEF.md
# USB OUT Endpoint Handshake Arbiter

This block picks the reply that a high-speed USB device endpoint sends back for OUT data transactions and for PING tokens. The FIFO storage lives elsewhere. The block sees only three things about it: a free-byte count, a used-byte count and the run-time maximum packet size. From these it grants or refuses room for the next packet. When room is tight it answers NYET, so the host has to PING before sending more data. A PING gets ACK as soon as one full packet fits and NAK otherwise.

A transaction is presented in one cycle on `tokValid`. In that cycle the caller also gives the token type, the packet-good flag, the data-PID sequence error flag, the packet length and the endpoint type. One cycle later the block raises a one-cycle handshake strobe with its code. In the same cycle it raises a commit strobe that tells the FIFO side to keep the packet, and an end-of-transfer interrupt pulse. A registered flag continuously reports whether one more maximum-size packet would fit.

Top module: `usb_out_hs`

## Requirements
- R1: A PING on a non-isochronous endpoint is answered with ACK (hsCode 2'b00) when fifoFree >= maxPkt, including when a NYET came just before.
- R2: A PING on a non-isochronous endpoint is answered with NAK (hsCode 2'b10) when fifoFree < maxPkt.
- R3: A good, non-isochronous OUT packet with no sequence error, with fifoFree >= maxPkt and with fifoUsed != 0 is committed, raises eotPulse and is answered with NYET (hsCode 2'b01) when fifoFree - pktLen < 2*maxPkt.
- R4: Such a packet is answered with ACK (2'b00), committed and flagged with eotPulse when fifoUsed == 0 or when fifoFree - pktLen >= 2*maxPkt.
- R5: A good non-isochronous OUT packet that arrives while fifoFree < maxPkt is answered with NAK (2'b10) and raises neither wrCommit nor eotPulse.
- R6: hsValid, wrCommit and eotPulse appear in the cycle after the clock edge that samples tokValid and last one cycle. hsCode is never 2'b11 while hsValid is high.
- R7: An isochronous endpoint never raises hsValid. A good isochronous OUT packet with room (fifoFree >= maxPkt) and no sequence error is committed and raises eotPulse. Without room it is dropped silently.
- R8: An isochronous OUT packet with a PID sequencing error raises neither eotPulse nor wrCommit.
- R9: An OUT packet with pktOk low gets no handshake, no commit and no eotPulse.
- R10: A good non-isochronous OUT packet with a data-toggle (sequence) error, arriving while there is room, is answered with ACK but raises neither wrCommit nor eotPulse.
- R11: roomOk equals (fifoFree >= maxPkt) as sampled at the previous clock edge.
- R12: While rstN is low, hsValid, hsCode, wrCommit, eotPulse and roomOk are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tokValid | input | 1 | One-cycle strobe: a transaction is presented |
| tokPing | input | 1 | 1 = PING token, 0 = OUT data transaction |
| pktOk | input | 1 | OUT data packet was received without error |
| pidSeqErr | input | 1 | Data PID did not match the expected sequence |
| isoEp | input | 1 | Endpoint is isochronous |
| maxPkt | input | MPS_W (11) | Maximum packet size in bytes, 1..1024 |
| pktLen | input | MPS_W (11) | Byte length of the OUT packet, at most maxPkt |
| fifoFree | input | MPS_W+2 (13) | Free bytes in the receive FIFO |
| fifoUsed | input | MPS_W+2 (13) | Bytes already held in the receive FIFO |
| hsValid | output | 1 | Handshake strobe |
| hsCode | output | 2 | 00 ACK, 01 NYET, 10 NAK |
| wrCommit | output | 1 | Keep the received packet in the FIFO |
| eotPulse | output | 1 | End-of-transfer interrupt pulse |
| roomOk | output | 1 | One more maximum-size packet fits |

## Verification
The assertions assume three things about the inputs: pktLen never exceeds maxPkt, maxPkt is not zero, and fifoFree plus fifoUsed stay within the 13-bit counter range. Under these assumptions the post-write free space cannot underflow. Every stimulus vector keeps pktLen at or below maxPkt and uses a non-zero size of 512 or 1024 bytes. The free counts are placed exactly on the one-packet and two-packet boundaries, and one step either side of them.

// File: rtl/usb_out_hs_pkg.sv
package usb_out_hs_pkg;

  typedef enum logic [1:0] {
    HS_ACK  = 2'b00,
    HS_NYET = 2'b01,
    HS_NAK  = 2'b10
  } hsCode_e;

  // control -> datapath
  typedef struct packed {
    logic    loadHs;
    hsCode_e code;
    logic    loadWr;
    logic    loadEot;
  } ctlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic geOne;      // free >= maxPkt
    logic ltTwoAfter; // free - len < 2*maxPkt
    logic hasData;    // fifo held bytes before the packet
  } dpFlag_t;

endpackage

// File: rtl/usb_out_hs_dp.sv
module usb_out_hs_dp
  import usb_out_hs_pkg::*;
#(
  parameter int MPS_W = 11,
  parameter int CNT_W = MPS_W + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [MPS_W-1:0] maxPkt,
  input  logic [MPS_W-1:0] pktLen,
  input  logic [CNT_W-1:0] fifoFree,
  input  logic [CNT_W-1:0] fifoUsed,
  input  ctlStrobe_t       strobe,
  output dpFlag_t          flags,
  output logic             hsValid,
  output logic [1:0]       hsCode,
  output logic             wrCommit,
  output logic             eotPulse,
  output logic             roomOk
);

  logic [CNT_W-1:0] oneMps;
  logic [CNT_W-1:0] twoMps;
  logic [CNT_W-1:0] freeAfter;

  always_comb begin
    oneMps           = CNT_W'(maxPkt);
    twoMps           = CNT_W'({maxPkt, 1'b0});
    freeAfter        = fifoFree - CNT_W'(pktLen);
    flags.geOne      = fifoFree >= oneMps;
    flags.ltTwoAfter = freeAfter < twoMps;
    flags.hasData    = fifoUsed != '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hsValid  <= 1'b0;
      hsCode   <= 2'b00;
      wrCommit <= 1'b0;
      eotPulse <= 1'b0;
      roomOk   <= 1'b0;
    end else begin
      hsValid  <= strobe.loadHs;
      hsCode   <= strobe.loadHs ? strobe.code : 2'b00;
      wrCommit <= strobe.loadWr;
      eotPulse <= strobe.loadEot;
      roomOk   <= flags.geOne;
    end
  end

endmodule

// File: rtl/usb_out_hs_ctl.sv
module usb_out_hs_ctl
  import usb_out_hs_pkg::*;
(
  input  logic       tokValid,
  input  logic       tokPing,
  input  logic       pktOk,
  input  logic       pidSeqErr,
  input  logic       isoEp,
  input  dpFlag_t    flags,
  output ctlStrobe_t strobe
);

  always_comb begin
    strobe = '{loadHs: 1'b0, code: HS_ACK, loadWr: 1'b0, loadEot: 1'b0};
    if (tokValid) begin
      if (tokPing) begin
        // flow-control probe: one packet of room is enough
        strobe.loadHs = !isoEp;
        strobe.code   = flags.geOne ? HS_ACK : HS_NAK;
      end else if (pktOk) begin
        if (!flags.geOne) begin
          // no room: drop, refuse
          strobe.loadHs = !isoEp;
          strobe.code   = HS_NAK;
        end else if (pidSeqErr) begin
          // toggle mismatch: acknowledge, discard
          strobe.loadHs = !isoEp;
          strobe.code   = HS_ACK;
        end else begin
          strobe.loadWr  = 1'b1;
          strobe.loadEot = 1'b1;
          strobe.loadHs  = !isoEp;
          strobe.code    = (flags.hasData && flags.ltTwoAfter) ? HS_NYET : HS_ACK;
        end
      end
    end
  end

endmodule

// File: rtl/usb_out_hs.sv
module usb_out_hs
  import usb_out_hs_pkg::*;
#(
  parameter int MPS_W = 11,
  localparam int CNT_W = MPS_W + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tokValid,
  input  logic             tokPing,
  input  logic             pktOk,
  input  logic             pidSeqErr,
  input  logic             isoEp,
  input  logic [MPS_W-1:0] maxPkt,
  input  logic [MPS_W-1:0] pktLen,
  input  logic [CNT_W-1:0] fifoFree,
  input  logic [CNT_W-1:0] fifoUsed,
  output logic             hsValid,
  output logic [1:0]       hsCode,
  output logic             wrCommit,
  output logic             eotPulse,
  output logic             roomOk
);

  ctlStrobe_t strobe;
  dpFlag_t    flags;

  usb_out_hs_ctl u_ctl (
    .tokValid (tokValid),
    .tokPing  (tokPing),
    .pktOk    (pktOk),
    .pidSeqErr(pidSeqErr),
    .isoEp    (isoEp),
    .flags    (flags),
    .strobe   (strobe)
  );

  usb_out_hs_dp #(.MPS_W(MPS_W), .CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .maxPkt  (maxPkt),
    .pktLen  (pktLen),
    .fifoFree(fifoFree),
    .fifoUsed(fifoUsed),
    .strobe  (strobe),
    .flags   (flags),
    .hsValid (hsValid),
    .hsCode  (hsCode),
    .wrCommit(wrCommit),
    .eotPulse(eotPulse),
    .roomOk  (roomOk)
  );

endmodule

// File: rtl/usb_out_hs_chk.sv
module usb_out_hs_chk #(
  parameter int MPS_W = 11,
  localparam int CNT_W = MPS_W + 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             tokValid,
  input logic             tokPing,
  input logic             pktOk,
  input logic             pidSeqErr,
  input logic             isoEp,
  input logic [MPS_W-1:0] maxPkt,
  input logic [CNT_W-1:0] fifoFree,
  input logic             hsValid,
  input logic [1:0]       hsCode,
  input logic             wrCommit,
  input logic             eotPulse
);

  // R1
  ping_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tokValid && tokPing && !isoEp && (fifoFree >= CNT_W'(maxPkt)))
      |=> (hsValid && hsCode == 2'b00));

  // R2
  ping_nak_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tokValid && tokPing && !isoEp && (fifoFree < CNT_W'(maxPkt)))
      |=> (hsValid && hsCode == 2'b10));

  // R5
  nak_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hsValid && hsCode == 2'b10) |-> (!wrCommit && !eotPulse));

  // R6
  code_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    hsValid |-> (hsCode != 2'b11));

  // R6
  no_token_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tokValid |=> (!hsValid && !wrCommit && !eotPulse));

  // R7
  iso_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tokValid && isoEp) |=> !hsValid);

  // R8
  iso_seq_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tokValid && isoEp && !tokPing && pidSeqErr) |=> (!eotPulse && !wrCommit));

  // R9
  bad_pkt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tokValid && !tokPing && !pktOk) |=> (!hsValid && !wrCommit && !eotPulse));

endmodule

bind usb_out_hs usb_out_hs_chk #(.MPS_W(MPS_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .tokValid (tokValid),
  .tokPing  (tokPing),
  .pktOk    (pktOk),
  .pidSeqErr(pidSeqErr),
  .isoEp    (isoEp),
  .maxPkt   (maxPkt),
  .fifoFree (fifoFree),
  .hsValid  (hsValid),
  .hsCode   (hsCode),
  .wrCommit (wrCommit),
  .eotPulse (eotPulse)
);

// File: tb/usb_out_hs_bench.sv
module usb_out_hs_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tokValid = 1'b0, tokPing = 1'b0, pktOk = 1'b0, pidSeqErr = 1'b0, isoEp = 1'b0;
  logic [10:0] maxPkt = 11'd512, pktLen = 11'd0;
  logic [12:0] fifoFree = 13'd0, fifoUsed = 13'd0;
  logic        hsValid, wrCommit, eotPulse, roomOk;
  logic [1:0]  hsCode;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  usb_out_hs u_usb_out_hs (
    .clk(clk), .rstN(rstN), .tokValid(tokValid), .tokPing(tokPing), .pktOk(pktOk),
    .pidSeqErr(pidSeqErr), .isoEp(isoEp), .maxPkt(maxPkt), .pktLen(pktLen),
    .fifoFree(fifoFree), .fifoUsed(fifoUsed), .hsValid(hsValid), .hsCode(hsCode),
    .wrCommit(wrCommit), .eotPulse(eotPulse), .roomOk(roomOk)
  );

  typedef struct packed {
    logic        ping, iso, ok, perr;
    logic [10:0] mps;
    logic [12:0] free, used;
    logic [10:0] len;
    logic        ev;
    logic [1:0]  ec;
    logic        ew, ee;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 17;
  // codes: 0 ACK, 1 NYET, 2 NAK
  localparam vec_t VECS [NV] = '{
    '{1,0,0,0, 512,  600,    0,    0, 1,0,0,0, 1},  // R1
    '{1,0,0,0, 512,  511,    0,    0, 1,2,0,0, 2},  // R2
    '{1,0,0,0, 512,  512,    0,    0, 1,0,0,0, 1},  // R1 boundary
    '{0,0,1,0, 512, 1500,  100,  512, 1,1,1,1, 3},  // R3
    '{0,0,1,0, 512, 1024,    0,  512, 1,0,1,1, 4},  // R4 empty fifo
    '{0,0,1,0, 512, 1600,  200,   64, 1,0,1,1, 4},  // R4
    '{0,0,1,0, 512, 1536,  200,  512, 1,0,1,1, 4},  // R4 exact 2x
    '{0,0,1,0, 512, 1535,  200,  512, 1,1,1,1, 3},  // R3 one below
    '{0,0,1,0, 512,  511,  300,  100, 1,2,0,0, 5},  // R5
    '{0,0,0,0, 512, 2000,    0,  100, 0,0,0,0, 9},  // R9
    '{0,1,1,0, 512, 2000,    0,  512, 0,0,1,1, 7},  // R7
    '{0,1,1,1, 512, 2000,    0,  512, 0,0,0,0, 8},  // R8
    '{0,0,1,1, 512, 2000,   10,  100, 1,0,0,0,10},  // R10
    '{0,0,1,0,1024, 4095,    1, 1024, 1,0,1,1, 4},  // R4 large mps
    '{0,0,1,0,1024, 3000,    1, 1024, 1,1,1,1, 3},  // R3 3x fifo
    '{1,0,0,0,1024, 1976,    0,    0, 1,0,0,0, 1},  // R1 ping after NYET
    '{0,1,1,0, 512,  100,    0,   64, 0,0,0,0, 7}   // R7 no room
  };

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stim
    // R12 reset state
    fifoFree = 13'd2000;
    repeat (3) @(negedge clk);
    check("R12 hsValid", int'(hsValid), 0);
    check("R12 hsCode", int'(hsCode), 0);
    check("R12 wrCommit", int'(wrCommit), 0);
    check("R12 eotPulse", int'(eotPulse), 0);
    check("R12 roomOk", int'(roomOk), 0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      tokPing = VECS[i].ping; isoEp = VECS[i].iso; pktOk = VECS[i].ok;
      pidSeqErr = VECS[i].perr; maxPkt = VECS[i].mps; fifoFree = VECS[i].free;
      fifoUsed = VECS[i].used; pktLen = VECS[i].len; tokValid = 1'b1;
      @(negedge clk);
      tokValid = 1'b0;
      check($sformatf("R%0d hsValid v%0d", VECS[i].req, i), int'(hsValid), int'(VECS[i].ev));
      if (VECS[i].ev)
        check($sformatf("R%0d hsCode v%0d", VECS[i].req, i), int'(hsCode), int'(VECS[i].ec));
      check($sformatf("R%0d wrCommit v%0d", VECS[i].req, i), int'(wrCommit), int'(VECS[i].ew));
      check($sformatf("R%0d eotPulse v%0d", VECS[i].req, i), int'(eotPulse), int'(VECS[i].ee));
      @(negedge clk);
      check($sformatf("R6 one-cycle hsValid v%0d", i), int'(hsValid), 0);
      check($sformatf("R6 one-cycle eot v%0d", i), int'(eotPulse), 0);
    end

    // R11 roomOk tracking, registered
    @(negedge clk);
    maxPkt = 11'd512; fifoFree = 13'd512;
    @(negedge clk);
    check("R11 roomOk at boundary", int'(roomOk), 1);
    fifoFree = 13'd511;
    check("R11 roomOk before edge", int'(roomOk), 1);
    @(negedge clk);
    check("R11 roomOk below", int'(roomOk), 0);

    // R6 back-to-back tokens: PING ACK then PING NAK
    fifoFree = 13'd700; tokPing = 1'b1; isoEp = 1'b0; tokValid = 1'b1;
    @(negedge clk);
    check("R6 b2b first valid", int'(hsValid), 1);
    check("R1 b2b first code", int'(hsCode), 0);
    fifoFree = 13'd100;
    @(negedge clk);
    tokValid = 1'b0;
    check("R6 b2b second valid", int'(hsValid), 1);
    check("R2 b2b second code", int'(hsCode), 2);

    // R12 reset in mid-stream clears outputs
    fifoFree = 13'd700; tokValid = 1'b1;
    @(negedge clk);
    tokValid = 1'b0; rstN = 1'b0;
    @(negedge clk);
    check("R12 reset clears hsValid", int'(hsValid), 0);
    check("R12 reset clears roomOk", int'(roomOk), 0);
    rstN = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule